// File: doc/BRIEF.md
# Correlator Input Test Vector Generator

This block sits in front of a cross-correlation engine and feeds it either live samples or one of three synthetic patterns. A 2-bit mode select picks between a passthrough path and three generators. In passthrough, the input word, its valid strobe and its sync pulse reach the outputs one clock later. In a generator mode, the block ignores the input stream. It drives valid on every cycle and makes its own sync pulse from a free-running frame counter.

Each data word carries two polarisations of complex samples. Every component is a two's-complement number of `SMP_W` bits with `SMP_W-1` fractional bits. The packing, from the top bits down, is pol-1 real, pol-1 imaginary, pol-2 real, pol-2 imaginary.

The three patterns are as follows:
- An antenna-index counter.
- A fixed set of fractional constants.
- A cyclic replay of eight user words.

The antenna count, the integration length and the frame length are all given as log2 parameters. The core of the block is a four-state machine (`ST_PASS`, `ST_COUNT`, `ST_CONST`, `ST_USER`). It leaves its current state only on the last cycle of a frame. At that point it takes the transition named by the select input:
- value 0 goes to `ST_PASS`;
- value 1 goes to `ST_COUNT`;
- value 2 goes to `ST_CONST`;
- value 3 goes to `ST_USER`.

A new pattern therefore always starts on a frame origin.

Top module: `corr_tvg`

## Requirements
- R1: In `ST_PASS`, `out_data`, `out_valid` and `out_sync` equal `in_data`, `in_valid` and `in_sync` of the previous clock.
- R2: In any generator state, `out_valid` is 1 on every cycle, and `in_data`, `in_valid` and `in_sync` have no effect on any output.
- R3: In a generator state, `out_sync` is a one-cycle pulse on the first word of every frame. A frame is 2^SYNC_LOG2 cycles long, and the first frame origin comes 2^SYNC_LOG2 clocks after reset release.
- R4: Word packing is [4W-1:3W] pol-1 real, [3W-1:2W] pol-1 imag, [2W-1:W] pol-2 real, [W-1:0] pol-2 imag. W is `SMP_W`, and each field is two's complement with W-1 fractional bits.
- R5: In `ST_COUNT` (select 1), antenna index k gives real = k and imag = -k in both polarisations. k advances every 2^INT_LOG2 cycles and wraps after 2^ANT_LOG2 antennas.
- R6: In `ST_COUNT`, a real part above 2^(W-1)-1 saturates to that maximum, and an imag part below -2^(W-1) saturates to that minimum.
- R7: In `ST_CONST` (select 2), every word holds pol-1 real 0.125, pol-1 imag -0.75, pol-2 real 0.5 and pol-2 imag -0.25. Each value is rounded to the nearest W-bit code, with ties away from zero.
- R8: In `ST_USER` (select 3), slot s = 0..7 outputs `user_vec[s*4W +: 4W]`. Each slot is held for 2^INT_LOG2 cycles, and slot 7 is followed by slot 0.
- R9: The antenna index and the user slot both restart at 0 on the first word of every frame.
- R10: A change on `mode_sel` changes the state only when sampled on the last cycle of a frame. The new mode governs the output from the next frame's first word on.
- R11: While `rst_n` is low, all outputs are 0, and the state is `ST_PASS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 passthrough, 1 antenna counter, 2 constants, 3 user words |
| user_vec | input | 8*4*SMP_W | Eight user words, slot 0 in the lowest bits |
| in_data | input | 4*SMP_W | Live sample word |
| in_valid | input | 1 | Live valid strobe |
| in_sync | input | 1 | Live sync pulse |
| out_data | output | 4*SMP_W | Registered output word |
| out_valid | output | 1 | Registered valid |
| out_sync | output | 1 | Registered sync |

## Verification
The hardest behaviour to reach from the ports is the deferred mode switch. `mode_sel` has to change at a known offset inside a frame, and the old pattern must be seen to continue until the frame ends. This includes a change on the very last cycle of a frame, which must still take effect.

The stimulus counts clocks from reset release, so it always knows the frame position. It changes the select mid-frame and again on the last cycle, and then checks every word of the following frames.

Saturation cannot occur at the default width. A second instance with 3-bit components is driven with the same select sequence, so its antenna counter runs past the representable range.

// File: rtl/tvg_pkg.sv
package tvg_pkg;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_COUNT = 2'd1,
        ST_CONST = 2'd2,
        ST_USER  = 2'd3
    } tvg_state_e;

    localparam int NUM_UV = 8;
    localparam int SLOT_W = $clog2(NUM_UV);

endpackage

// File: rtl/tvg_timebase.sv
// Frame counter plus the antenna and user-slot indices derived from it.
module tvg_timebase #(
    parameter int SYNC_LOG2 = 6,
    parameter int INT_LOG2  = 2,
    parameter int ANT_LOG2  = 3,
    parameter int SLOT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                frame_start,
    output logic                frame_last,
    output logic [ANT_LOG2-1:0] ant_idx,
    output logic [SLOT_W-1:0]   slot_idx
);

    logic [SYNC_LOG2-1:0] pos_q;
    logic [INT_LOG2-1:0]  dwell_q;
    logic [ANT_LOG2-1:0]  ant_q;
    logic [SLOT_W-1:0]    slot_q;
    logic                 step;

    assign frame_start = (pos_q == '0);
    assign frame_last  = (pos_q == '1);
    assign step        = (dwell_q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            dwell_q <= '0;
            ant_q   <= '0;
            slot_q  <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
            if (frame_last) begin
                dwell_q <= '0;
                ant_q   <= '0;
                slot_q  <= '0;
            end else begin
                dwell_q <= dwell_q + 1'b1;
                if (step) begin
                    ant_q  <= ant_q + 1'b1;
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign ant_idx  = ant_q;
    assign slot_idx = slot_q;

endmodule

// File: rtl/tvg_mode_fsm.sv
// Mode state machine: the state follows mode_sel only at a frame end.
module tvg_mode_fsm
    import tvg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       frame_last,
    output tvg_state_e state
);

    tvg_state_e state_q, state_d, sel_state;

    always_comb begin
        unique case (mode_sel)
            2'd0: sel_state = ST_PASS;
            2'd1: sel_state = ST_COUNT;
            2'd2: sel_state = ST_CONST;
            2'd3: sel_state = ST_USER;
            default: sel_state = ST_PASS;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS:  if (frame_last) state_d = sel_state;
            ST_COUNT: if (frame_last) state_d = sel_state;
            ST_CONST: if (frame_last) state_d = sel_state;
            ST_USER:  if (frame_last) state_d = sel_state;
            default:  state_d = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/tvg_pattern.sv
// Combinational word generator for the three synthetic patterns.
module tvg_pattern
    import tvg_pkg::*;
#(
    parameter int SMP_W    = 8,
    parameter int ANT_LOG2 = 3
) (
    input  tvg_state_e                   state,
    input  logic [ANT_LOG2-1:0]          ant_idx,
    input  logic [SLOT_W-1:0]            slot_idx,
    input  logic [NUM_UV*4*SMP_W-1:0]    user_vec,
    output logic [4*SMP_W-1:0]           word
);

    localparam int WORD_W = 4 * SMP_W;
    localparam int ONE    = 1 << (SMP_W - 1);
    localparam int MAXP   = ONE - 1;
    localparam int C_P1RE = (ONE + 4) / 8;
    localparam int C_P1IM = -((3 * ONE + 2) / 4);
    localparam int C_P2RE = (ONE + 1) / 2;
    localparam int C_P2IM = -((ONE + 2) / 4);

    logic [SMP_W-1:0] cnt_re, cnt_im;
    logic [WORD_W-1:0] cnt_word, const_word, user_word;

    always_comb begin
        if (int'(ant_idx) > MAXP) cnt_re = SMP_W'(MAXP);
        else                      cnt_re = SMP_W'(ant_idx);
        if (int'(ant_idx) > ONE)  cnt_im = SMP_W'(-ONE);
        else                      cnt_im = SMP_W'(-int'(ant_idx));
    end

    assign cnt_word   = {cnt_re, cnt_im, cnt_re, cnt_im};
    assign const_word = {SMP_W'(C_P1RE), SMP_W'(C_P1IM), SMP_W'(C_P2RE), SMP_W'(C_P2IM)};
    assign user_word  = user_vec[slot_idx*WORD_W +: WORD_W];

    always_comb begin
        unique case (state)
            ST_COUNT: word = cnt_word;
            ST_CONST: word = const_word;
            ST_USER:  word = user_word;
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/corr_tvg.sv
// Top: output registers choosing between live data and generated words.
module corr_tvg
    import tvg_pkg::*;
#(
    parameter int SMP_W     = 8,
    parameter int ANT_LOG2  = 3,
    parameter int INT_LOG2  = 2,
    parameter int SYNC_LOG2 = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  mode_sel,
    input  logic [NUM_UV*4*SMP_W-1:0]   user_vec,
    input  logic [4*SMP_W-1:0]          in_data,
    input  logic                        in_valid,
    input  logic                        in_sync,
    output logic [4*SMP_W-1:0]          out_data,
    output logic                        out_valid,
    output logic                        out_sync
);

    localparam int WORD_W = 4 * SMP_W;

    tvg_state_e          state;
    logic                frame_start, frame_last;
    logic [ANT_LOG2-1:0] ant_idx;
    logic [SLOT_W-1:0]   slot_idx;
    logic [WORD_W-1:0]   pat_word;

    tvg_timebase #(
        .SYNC_LOG2 (SYNC_LOG2),
        .INT_LOG2  (INT_LOG2),
        .ANT_LOG2  (ANT_LOG2),
        .SLOT_W    (SLOT_W)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_last  (frame_last),
        .ant_idx     (ant_idx),
        .slot_idx    (slot_idx)
    );

    tvg_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .frame_last (frame_last),
        .state      (state)
    );

    tvg_pattern #(
        .SMP_W    (SMP_W),
        .ANT_LOG2 (ANT_LOG2)
    ) u_pattern (
        .state    (state),
        .ant_idx  (ant_idx),
        .slot_idx (slot_idx),
        .user_vec (user_vec),
        .word     (pat_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_sync  <= 1'b0;
        end else begin
            unique case (state)
                ST_PASS: begin
                    out_data  <= in_data;
                    out_valid <= in_valid;
                    out_sync  <= in_sync;
                end
                ST_COUNT, ST_CONST, ST_USER: begin
                    out_data  <= pat_word;
                    out_valid <= 1'b1;
                    out_sync  <= frame_start;
                end
                default: begin
                    out_data  <= '0;
                    out_valid <= 1'b0;
                    out_sync  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/corr_tvg_checker.sv
module corr_tvg_checker
    import tvg_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int ANT_LOG2 = 3
) (
    input logic                clk,
    input logic                rst_n,
    input tvg_state_e          state,
    input logic                frame_start,
    input logic                frame_last,
    input logic [ANT_LOG2-1:0] ant_idx,
    input logic [SLOT_W-1:0]   slot_idx,
    input logic [WORD_W-1:0]   in_data,
    input logic                in_valid,
    input logic                in_sync,
    input logic [WORD_W-1:0]   out_data,
    input logic                out_valid,
    input logic                out_sync
);

    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PASS |=> (out_data == $past(in_data) && out_valid == $past(in_valid)
                              && out_sync == $past(in_sync))); // R1

    AST_GEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_PASS |=> out_valid); // R2

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sync && $past(state) != ST_PASS) |=> !out_sync); // R3

    AST_ANT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> (ant_idx == $past(ant_idx) || ant_idx == ANT_LOG2'($past(ant_idx) + 1'b1))); // R5

    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (ant_idx == '0 && slot_idx == '0)); // R9

    AST_MODE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_last) |-> $stable(state)); // R10

endmodule

bind corr_tvg corr_tvg_checker #(
    .WORD_W   (WORD_W),
    .ANT_LOG2 (ANT_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .frame_start (frame_start),
    .frame_last  (frame_last),
    .ant_idx     (ant_idx),
    .slot_idx    (slot_idx),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_sync     (in_sync),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_sync    (out_sync)
);

// File: tb/test_corr_tvg.sv
module test_corr_tvg;

    localparam int SW    = 8;
    localparam int AL    = 3;
    localparam int IL    = 2;
    localparam int SL    = 6;
    localparam int WW    = 4 * SW;
    localparam int NW    = 3;
    localparam int NWW   = 4 * NW;
    localparam int FRAME = 1 << SL;

    localparam logic [WW+1:0] PASS_VEC [8] = '{
        {32'hDEAD_BEEF, 1'b1, 1'b0},
        {32'h0000_0000, 1'b0, 1'b1},
        {32'hFFFF_FFFF, 1'b1, 1'b1},
        {32'h1234_5678, 1'b0, 1'b0},
        {32'h8000_0001, 1'b1, 1'b0},
        {32'h7F80_807F, 1'b1, 1'b1},
        {32'h0F0F_F0F0, 1'b0, 1'b1},
        {32'hA5A5_5A5A, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] mode_sel;
    logic [8*WW-1:0] uv;
    logic [WW-1:0] in_data;
    logic in_valid, in_sync;
    logic [WW-1:0] out_data;
    logic out_valid, out_sync;
    logic [NWW-1:0] out_data_n;
    logic out_valid_n, out_sync_n;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    corr_tvg #(.SMP_W(SW), .ANT_LOG2(AL), .INT_LOG2(IL), .SYNC_LOG2(SL)) i_corr_tvg (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .user_vec(uv),
        .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync),
        .out_data(out_data), .out_valid(out_valid), .out_sync(out_sync));

    corr_tvg #(.SMP_W(NW), .ANT_LOG2(AL), .INT_LOG2(IL), .SYNC_LOG2(SL)) i_corr_tvg_narrow (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .user_vec(uv[8*NWW-1:0]),
        .in_data(in_data[NWW-1:0]), .in_valid(in_valid), .in_sync(in_sync),
        .out_data(out_data_n), .out_valid(out_valid_n), .out_sync(out_sync_n));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    function automatic logic [63:0] pack(int w, int a, int b, int c, int d);
        logic [63:0] r = '0;
        int v[4];
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        for (int i = 0; i < 4; i++)
            for (int bit_i = 0; bit_i < w; bit_i++)
                r[(3 - i) * w + bit_i] = v[i][bit_i];
        return r;
    endfunction

    function automatic logic [63:0] exp_gen(int mode, int p, int w);
        int blk   = p >> IL;
        int ant   = blk % (1 << AL);
        int slot  = blk % 8;
        int maxv  = (1 << (w - 1)) - 1;
        int minv  = -(1 << (w - 1));
        int re, im;
        real sc   = 2.0 ** (w - 1);
        logic [63:0] r = '0;
        case (mode)
            1: begin
                re = (ant > maxv) ? maxv : ant;
                im = (-ant < minv) ? minv : -ant;
                r  = pack(w, re, im, re, im);
            end
            2: r = pack(w, int'(0.125 * sc), int'(-0.75 * sc), int'(0.5 * sc), int'(-0.25 * sc));
            default: begin
                for (int bit_i = 0; bit_i < 4 * w; bit_i++)
                    r[bit_i] = uv[slot * 4 * w + bit_i];
            end
        endcase
        return r;
    endfunction

    // One generator frame: checks every word, optionally changes select at offset sw_at.
    task automatic run_frame(int mode, int next_sel, int sw_at, string tag, string tag_n);
        for (int p = 0; p < FRAME; p++) begin
            in_data  = 32'hCAFE_0000 ^ WW'(p * 32'h0101_0101);
            in_valid = 1'b0;
            in_sync  = 1'b1;
            if (p == sw_at) mode_sel = 2'(next_sel);
            tick();
            chk({tag, " R4 R9 R10 data"}, 64'(out_data), exp_gen(mode, p, SW));
            chk({tag_n, " narrow data"}, 64'(out_data_n), exp_gen(mode, p, NW));
            chk("R2 valid held", 64'(out_valid), 64'd1);
            chk("R3 sync at frame origin", 64'(out_sync), 64'(p == 0));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int s = 0; s < 8; s++)
            uv[s * WW +: WW] = {8'(s * 17 + 3), 8'(~s), 8'(s << 4), 8'(8'hA5 ^ s)};
        rst_n    = 1'b0;
        mode_sel = 2'd1;
        in_data  = 32'h5555_AAAA;
        in_valid = 1'b1;
        in_sync  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset data",  64'(out_data),  64'd0);
        chk("R11 reset valid", 64'(out_valid), 64'd0);
        chk("R11 reset sync",  64'(out_sync),  64'd0);
        mode_sel = 2'd0;
        rst_n    = 1'b1;
        cyc      = 0;

        // vector table in passthrough
        for (int i = 0; i < 8; i++) begin
            {in_data, in_valid, in_sync} = PASS_VEC[i];
            tick();
            chk("R1 pass data",  64'(out_data),  64'(PASS_VEC[i][WW+1:2]));
            chk("R1 pass valid", 64'(out_valid), 64'(PASS_VEC[i][1]));
            chk("R1 pass sync",  64'(out_sync),  64'(PASS_VEC[i][0]));
            chk("R1 narrow data", 64'(out_data_n), 64'(PASS_VEC[i][NWW+1:2]));
        end

        // select changed mid-frame: passthrough must continue to the frame end
        mode_sel = 2'd1;
        while (cyc < FRAME) begin
            in_data  = WW'(cyc * 32'h0103_0507);
            in_valid = cyc[0];
            in_sync  = (cyc % 5 == 0);
            tick();
            chk("R10 still pass data",  64'(out_data),  64'(in_data));
            chk("R10 still pass valid", 64'(out_valid), 64'(in_valid));
            chk("R10 still pass sync",  64'(out_sync),  64'(in_sync));
        end

        run_frame(1, 2, 20, "R5", "R6");
        run_frame(2, 3, 40, "R7", "R7");
        run_frame(3, 0, FRAME - 1, "R8", "R8");

        // back to passthrough after a last-cycle change
        for (int p = 0; p < 8; p++) begin
            in_data  = 32'h1357_9BDF + WW'(p);
            in_valid = p[0];
            in_sync  = p[1];
            tick();
            chk("R10 R1 return data",  64'(out_data),  64'(in_data));
            chk("R10 R1 return valid", 64'(out_valid), 64'(in_valid));
            chk("R10 R1 return sync",  64'(out_sync),  64'(in_sync));
        end
        summary();
    end

endmodule